// File: doc/BRIEF.md
# Fully Associative Translation Cache with Permission Check

This block holds a small set of recent virtual-to-physical page mappings and answers a lookup in the same cycle it is presented. A lookup carries a virtual page number, the in-page offset, whether the access is a write, and whether the requester runs in user mode. Every stored tag is compared with the requested page number in parallel. On a match the stored permissions are checked. The block then reports one of three outcomes: a translated physical address, a permission fault, or a miss that tells a table walker to fetch the mapping.

A refill port, using a valid/ready handshake, installs mappings delivered by the walker. A refill whose page number is already present rewrites that entry. Otherwise the lowest-numbered empty slot is used. When no slot is empty, a first-in-first-out pointer picks the entry to replace. A flush input empties the whole array in one cycle.

Back-pressure rules: a lookup needs no handshake, and its result is valid combinationally while `lk_valid` is high. A refill is taken on a rising clock edge where `rf_valid` and `rf_ready` are both high. `rf_ready` is low only in a cycle where `flush` is high. The refilled mapping can be looked up from the cycle after it is taken.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss, and the replacement pointer starts at entry 0.
- R2: A lookup that matches a valid entry and is permitted raises `lk_hit` in the same cycle, with `lk_paddr` = {stored physical page, `lk_off`}.
- R3: With `lk_valid` high, exactly one of `lk_hit`, `lk_fault`, `lk_miss` is high, and `lk_miss` means no valid entry matches. With `lk_valid` low all three are low. `lk_paddr` is zero unless `lk_hit` is high.
- R4: A read (`lk_write`=0) to an entry whose read bit (`rf_perm[0]`) is clear raises `lk_fault`.
- R5: A write to an entry whose write bit (`rf_perm[1]`) is clear, or whose dirty bit (`rf_perm[2]`) is clear, raises `lk_fault`.
- R6: A user-mode access (`lk_user`=1) to an entry whose user bit (`rf_perm[3]`) is clear raises `lk_fault`. Supervisor-mode access ignores the user bit.
- R7: A refill is taken when `rf_valid` and `rf_ready` are both high. `rf_ready` is low exactly in cycles with `flush` high. A taken mapping hits from the next cycle.
- R8: A refill with a new page number fills the lowest-numbered empty entry without moving the replacement pointer.
- R9: When all entries are valid, a refill with a new page number replaces the entry at the pointer, and the pointer then advances by one, wrapping after the last entry.
- R10: A refill whose page number matches a valid entry rewrites that entry in place, leaves the pointer unchanged and keeps the other entries.
- R11: `flush` empties all entries and resets the pointer to 0 at the clock edge. A lookup in the flush cycle reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset, passed through |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| lk_hit | output | 1 | Permitted translation |
| lk_fault | output | 1 | Match found but access denied |
| lk_miss | output | 1 | No matching entry |
| lk_paddr | output | PPN_W+OFF_W | Physical address on hit |
| rf_valid | input | 1 | Refill mapping offered |
| rf_ready | output | 1 | Refill can be taken |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_perm | input | 4 | {user, dirty, write, read} bits |

## Verification
FIFO replacement is the hardest behaviour to reach from the ports. The pointer only moves once every slot is valid, so the stimulus first streams enough distinct refills to fill the array. It then sends new page numbers and watches which older mappings start to miss. The same fill sequence is repeated after a flush, which shows that the pointer went back to entry 0. A duplicate refill before the array is full checks that in-place rewrites neither use a slot nor move the pointer.

// File: rtl/tlb_xlat_pkg.sv
package tlb_xlat_pkg;
  // permission bits of one mapping; packing order matches rf_perm
  typedef struct packed {
    logic usr;
    logic dirty;
    logic wr;
    logic rd;
  } perm_t;

  localparam int PERM_W = $bits(perm_t);
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  input  logic [VPN_W-1:0]   q_vpn,
  output logic [ENTRIES-1:0] q_match,
  output logic [ENTRIES-1:0] w_match,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PPN_W-1:0]   q_ppn,
  output perm_t              q_perm
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) begin
      tag_q[wr_idx]  <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  // parallel tag comparators for lookup and refill
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign q_match[g] = vld_q[g] && (tag_q[g] == q_vpn);
    assign w_match[g] = vld_q[g] && (tag_q[g] == wr_vpn);
  end

  assign valid_vec = vld_q;

  // one-hot OR mux of the matching entry
  always_comb begin
    q_ppn  = '0;
    q_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (q_match[i]) begin
        q_ppn  = q_ppn | ppn_q[i];
        q_perm = q_perm | perm_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               take,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  output logic [IDX_W-1:0]   sel_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] dup_idx, free_idx;
  logic             dup_any, free_any, use_ptr;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    dup_any  = 1'b0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i]) begin
        dup_idx = IDX_W'(i);
        dup_any = 1'b1;
      end
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  assign use_ptr = !dup_any && !free_any;
  assign sel_idx = dup_any ? dup_idx : (free_any ? free_idx : ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr_all) begin
      ptr_q <= '0;
    end else if (take && use_ptr) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_xlat_pkg::*;
(
  input  perm_t perm,
  input  logic  is_write,
  input  logic  is_user,
  output logic  allow
);
  logic mode_ok, type_ok;

  assign mode_ok = !is_user || perm.usr;
  assign type_ok = is_write ? (perm.wr && perm.dirty) : perm.rd;
  assign allow   = mode_ok && type_ok;
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [OFF_W-1:0]  lk_off,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [PERM_W-1:0] rf_perm
);
  logic [ENTRIES-1:0] q_match, w_match, valid_vec;
  logic [PPN_W-1:0]   q_ppn;
  perm_t              q_perm;
  logic [IDX_W-1:0]   sel_idx;
  logic               take, found, allow;

  assign rf_ready = !flush;
  assign take     = rf_valid && rf_ready;

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (flush),
    .wr_en    (take),
    .wr_idx   (sel_idx),
    .wr_vpn   (rf_vpn),
    .wr_ppn   (rf_ppn),
    .wr_perm  (perm_t'(rf_perm)),
    .q_vpn    (lk_vpn),
    .q_match  (q_match),
    .w_match  (w_match),
    .valid_vec(valid_vec),
    .q_ppn    (q_ppn),
    .q_perm   (q_perm)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_vsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (flush),
    .take     (take),
    .valid_vec(valid_vec),
    .dup_vec  (w_match),
    .sel_idx  (sel_idx)
  );

  tlb_perm_check u_perm (
    .perm    (q_perm),
    .is_write(lk_write),
    .is_user (lk_user),
    .allow   (allow)
  );

  assign found    = lk_valid && !flush && (|q_match);
  assign lk_hit   = found && allow;
  assign lk_fault = found && !allow;
  assign lk_miss  = lk_valid && !found;
  assign lk_paddr = lk_hit ? {q_ppn, lk_off} : '0;
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic [OFF_W-1:0] lk_off,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic             lk_miss,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             rf_ready
);
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_fault, lk_miss}) == (lk_valid ? 1 : 0));

  p_addr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_paddr == '0);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_off);

  p_ready_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_ready == !flush);

  p_flush_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lk_hit && !lk_fault);

  p_after_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit && !lk_fault);
endmodule

bind tlb_xlat tlb_xlat_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .lk_off(lk_off), .lk_hit(lk_hit), .lk_fault(lk_fault),
  .lk_miss(lk_miss), .lk_paddr(lk_paddr), .rf_ready(rf_ready)
);

// File: tb/tlb_xlat_bench.sv
`timescale 1ns/1ps
module tlb_xlat_bench;
  localparam int N = 32;

  logic        clk = 0, rst_n = 0, flush = 0;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic        lk_hit, lk_fault, lk_miss, rf_ready;
  logic [31:0] lk_paddr;
  logic        rf_valid = 0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  logic [3:0]  rf_perm = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit          m_v    [N];
  logic [19:0] m_vpn  [N];
  logic [19:0] m_ppn  [N];
  logic [3:0]  m_perm [N];
  int          m_ptr = 0;

  always #10 clk = ~clk;

  tlb_xlat u_tlb_xlat (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .rf_valid(rf_valid), .rf_ready(rf_ready),
    .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_perm(rf_perm)
  );

  task automatic compare(string tag);
    bit e_found = 0, e_allow = 0, e_hit, e_fault, e_miss, e_rdy;
    logic [31:0] e_pa;
    logic [3:0]  p = '0;
    logic [19:0] pp = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == lk_vpn) begin e_found = 1; p = m_perm[i]; pp = m_ppn[i]; end
    e_found = e_found && lk_valid && !flush;
    // perm bits: [0] read, [1] write, [2] dirty, [3] user
    e_allow = (!lk_user || p[3]) && (lk_write ? (p[1] && p[2]) : p[0]);
    e_hit   = e_found && e_allow;
    e_fault = e_found && !e_allow;
    e_miss  = lk_valid && !e_found;
    e_pa    = e_hit ? {pp, lk_off} : 32'h0;
    e_rdy   = !flush;
    checks++;
    if ({lk_hit, lk_fault, lk_miss, rf_ready} !== {e_hit, e_fault, e_miss, e_rdy}
        || lk_paddr !== e_pa) begin
      fails++;
      $display("FAIL %s: hit/fault/miss/rdy=%b pa=%h expected %b pa=%h", tag,
               {lk_hit, lk_fault, lk_miss, rf_ready}, lk_paddr,
               {e_hit, e_fault, e_miss, e_rdy}, e_pa);
    end
  endtask

  task automatic model_update();
    int idx = -1;
    if (flush) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
      return;
    end
    if (!rf_valid) return;
    for (int i = 0; i < N; i++) if (idx < 0 && m_v[i] && m_vpn[i] == rf_vpn) idx = i;
    if (idx < 0) for (int i = 0; i < N; i++) if (idx < 0 && !m_v[i]) idx = i;
    if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
    m_v[idx] = 1; m_vpn[idx] = rf_vpn; m_ppn[idx] = rf_ppn; m_perm[idx] = rf_perm;
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(string tag, bit lv, logic [19:0] vpn, bit wr, bit usr,
                      bit rv, logic [19:0] rvpn, logic [19:0] rppn,
                      logic [3:0] rperm, bit fl);
    lk_valid = lv; lk_vpn = vpn; lk_write = wr; lk_user = usr;
    lk_off = 12'(vpn * 7 + 3);
    rf_valid = rv; rf_vpn = rvpn; rf_ppn = rppn; rf_perm = rperm; flush = fl;
    #2 compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic look(string tag, logic [19:0] vpn, bit wr, bit usr);
    step(tag, 1, vpn, wr, usr, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string tag, logic [19:0] vpn, logic [19:0] ppn, logic [3:0] perm);
    step(tag, 0, 0, 0, 0, 1, vpn, ppn, perm, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    look("R1", 20'h00005, 0, 0);
    look("R1", 20'h00000, 1, 1);
    // R3: idle lookup gives no outcome
    step("R3", 0, 20'h00005, 0, 0, 0, 0, 0, 0, 0);
    // R7/R2: refill then hit next cycle
    fill("R7", 20'h00100, 20'h00ABC, 4'b1111);
    look("R2", 20'h00100, 0, 1);
    look("R2", 20'h00100, 1, 1);
    // R6 and R5 with a supervisor read-only entry
    fill("R8", 20'h00101, 20'h00111, 4'b0001);
    look("R6", 20'h00101, 0, 1);
    look("R6", 20'h00101, 0, 0);
    look("R5", 20'h00101, 1, 0);
    // R5: writable but clean
    fill("R8", 20'h00102, 20'h00222, 4'b0011);
    look("R5", 20'h00102, 1, 0);
    look("R2", 20'h00102, 0, 0);
    // R4: write-only dirty, not readable
    fill("R8", 20'h00103, 20'h00333, 4'b0110);
    look("R4", 20'h00103, 0, 0);
    look("R4", 20'h00103, 1, 0);
    look("R3", 20'h00999, 0, 0);
    // R10: duplicate rewrites in place
    fill("R10", 20'h00100, 20'h00555, 4'b1111);
    look("R10", 20'h00100, 0, 1);
    look("R10", 20'h00101, 0, 0);
    // R8: fill the remaining empty slots
    for (int i = 0; i < N - 4; i++) fill("R8", 20'h00200 + 20'(i), 20'h01000 + 20'(i), 4'b0111);
    look("R8", 20'h00203, 1, 0);
    look("R8", 20'h00100, 0, 0);
    // R9: full, FIFO evicts slot 0 then slot 1
    fill("R9", 20'h00300, 20'h03000, 4'b1111);
    look("R9", 20'h00100, 0, 0);
    look("R9", 20'h00101, 0, 0);
    fill("R9", 20'h00301, 20'h03001, 4'b1111);
    look("R9", 20'h00101, 0, 0);
    look("R9", 20'h00102, 1, 0);
    look("R9", 20'h00300, 0, 1);
    // R11: flush with same-cycle lookup and refill offer
    step("R11", 1, 20'h00300, 0, 0, 1, 20'h00777, 20'h00777, 4'b1111, 1);
    look("R11", 20'h00300, 0, 0);
    look("R7", 20'h00777, 0, 0);
    // R11: pointer back to 0 after flush
    for (int i = 0; i < N; i++) fill("R11", 20'h00400 + 20'(i), 20'h04000 + 20'(i), 4'b0001);
    fill("R11", 20'h00500, 20'h05000, 4'b0001);
    look("R11", 20'h00400, 0, 0);
    look("R11", 20'h00401, 0, 0);
    look("R9", 20'h00500, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule